// File: doc/BRIEF.md
# Pen-Down Scan Trigger Sequencer

This block sits between the pen-down line of a resistive touch controller and the engine that runs a conversion scan over its serial link. It turns that level-sensitive line into a paced series of one-cycle scan-start pulses. While a pen is on the panel it requests scans at a programmable interval. After the pen lifts it keeps requesting scans for a fixed number of extra intervals, and then it goes quiet until the next touch.

The pen line is disturbed whenever the scan engine switches channels. For this reason the block masks the pen interrupt for the whole of each scan and for the first polls after a touch. It unmasks the interrupt only partway through the trailing poll window.

Each scan-done pulse reloads an internal countdown with the interval minus the measured scan length. The start-to-start spacing therefore stays close to the programmed interval. A scan that runs too long sets a sticky overrun flag.

Top module: `pen_scan_trigger`

## Requirements
- R1: After reset, `state` reads OFF, `irq_mask` is high, and both `scan_start` and `overrun` are low. The `state` encoding is OFF=0, IDLE=1, POLL_MASKED=2, POLL_ARMED=3, SCAN=4.
- R2: A rising `trig_en` while in OFF moves the block to IDLE and clears `irq_mask` at the next clock edge.
- R3: A falling `trig_en` in any state moves the block to OFF and raises `irq_mask` at the next edge. It also cancels the pending countdown, so no scan pulse follows.
- R4: `pen_irq` passes through a two-flop synchroniser. A high level is acted on at the third rising edge after it is applied. It is ignored entirely while `irq_mask` is high or the state is OFF.
- R5: An accepted pen interrupt enters SCAN, raises `irq_mask`, clears the poll count and gives a `scan_start` pulse exactly one cycle wide.
- R6: When `scan_done` arrives D cycles after `scan_start` with D below the interval I, the countdown is reloaded with I-D. The block therefore leaves SCAN I+1 edges after the edge that raised `scan_start`.
- R7: When the countdown expires in SCAN with a poll count below 6, the count increments and the countdown reloads with the full interval. The next state is POLL_MASKED (mask high) if the new count is below 3, and POLL_ARMED (mask low) otherwise.
- R8: When the countdown expires in SCAN with the poll count at 6, the block goes to IDLE with the mask low. A single touch therefore yields exactly 7 scan pulses.
- R9: When the countdown expires in POLL_MASKED or POLL_ARMED, the block raises the mask, enters SCAN and pulses `scan_start`, I edges after it entered the poll state.
- R10: If the scan length D reaches or exceeds I, the reload value becomes 1, so the block leaves SCAN D+2 edges after `scan_start`. `overrun` is then set and stays set until reset.
- R11: While in IDLE or OFF without stimulus, the state holds and no scan pulse appears.
- R12: A pen interrupt accepted in POLL_ARMED restarts the sequence with a cleared poll count, giving a further 7 scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en | input | 1 | Trigger enable level |
| pen_irq | input | 1 | Asynchronous pen-down level, active high |
| scan_done | input | 1 | One-cycle pulse marking the end of a scan |
| scan_interval | input | TW (24) | Scan interval in clock cycles |
| scan_start | output | 1 | One-cycle pulse requesting a scan |
| irq_mask | output | 1 | High while the pen interrupt is masked |
| state | output | 3 | Current sequencer state |
| overrun | output | 1 | Sticky flag: a scan lasted at least one interval |

## Verification
The bench times every transition in clock edges, so each kind of mistake shows up as a specific wrong number:
- A reload that ignores the measured scan length shifts the exit from SCAN away from I+1 edges.
- An overrun that is not saturated to one cycle either wraps the countdown to a huge value or misses the D+2 exit.
- An off-by-one in the poll counter changes the count of 7 scans, or unmasks the interrupt one poll too early or too late.
- A retrigger in POLL_ARMED that fails to clear the count ends the second burst early.
- A disable that leaves the countdown running produces a stray scan pulse inside the quiet window.
- A pen path that bypasses the mask or the synchroniser reacts in OFF, or after fewer than three edges.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    ST_OFF         = 3'd0,
    ST_IDLE        = 3'd1,
    ST_POLL_MASKED = 3'd2,
    ST_POLL_ARMED  = 3'd3,
    ST_SCAN        = 3'd4
  } trig_state_t;
endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= d;
      end
      assign q = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pst_timer.sv
module pst_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          cancel,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cancel)        cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == TW'(1));

  // R3: a cancelled countdown cannot fire on the following cycle
  a_r3_cancel_silences: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !expire);
  // R9: one expiry per load
  a_r9_single_expiry: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/pst_meter.sv
module pst_meter #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          done,
  input  logic [TW-1:0] interval,
  output logic          accept,
  output logic [TW-1:0] reload,
  output logic          overrun
);
  logic          busy_q;
  logic [TW-1:0] meas_q;
  logic          ovr_q;
  logic          late;

  assign late    = (meas_q >= interval);
  assign accept  = busy_q && done;
  assign reload  = late ? TW'(1) : (interval - meas_q);
  assign overrun = ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      meas_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        meas_q <= TW'(1);
      end else if (accept) begin
        busy_q <= 1'b0;
      end else if (busy_q && meas_q != '1) begin
        meas_q <= meas_q + 1'b1;
      end
      if (accept && late) ovr_q <= 1'b1;
    end
  end

  // R10: overrun is sticky until reset
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R10: the countdown is never reloaded with zero
  a_r10_reload_nonzero: assert property (@(posedge clk) disable iff (rst)
    accept |-> (reload != '0));
endmodule

// File: rtl/pen_scan_trigger.sv
module pen_scan_trigger
  import pst_pkg::*;
#(
  parameter int TW          = 24,
  parameter int MIN_POLLS   = 3,
  parameter int EXT_POLLS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_en,
  input  logic          pen_irq,
  input  logic          scan_done,
  input  logic [TW-1:0] scan_interval,
  output logic          scan_start,
  output logic          irq_mask,
  output logic [2:0]    state,
  output logic          overrun
);
  localparam int TOTAL_POLLS = MIN_POLLS + EXT_POLLS;
  localparam int CW          = $clog2(TOTAL_POLLS + 1);

  trig_state_t   st_q;
  logic          mask_q;
  logic          scan_q;
  logic          en_q;
  logic [CW-1:0] polls_q;

  logic          pen_s;
  logic          en_rise, en_fall, pen_go;
  logic          expire, t_load, t_cancel;
  logic [TW-1:0] t_val;
  logic          m_accept;
  logic [TW-1:0] m_reload;
  logic          polls_left;
  logic [CW-1:0] polls_nx;

  pst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (pen_irq), .q (pen_s)
  );

  assign en_rise    = trig_en && !en_q;
  assign en_fall    = !trig_en && en_q;
  assign pen_go     = pen_s && !mask_q && (st_q != ST_OFF);
  assign polls_left = (polls_q < CW'(TOTAL_POLLS));
  assign polls_nx   = polls_q + 1'b1;

  pst_meter #(.TW(TW)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .start    (scan_q),
    .done     (scan_done && (st_q == ST_SCAN)),
    .interval (scan_interval),
    .accept   (m_accept),
    .reload   (m_reload),
    .overrun  (overrun)
  );

  always_comb begin
    t_cancel = en_fall || pen_go;
    t_load   = 1'b0;
    t_val    = scan_interval;
    if (!t_cancel) begin
      if (m_accept) begin
        t_load = 1'b1;
        t_val  = m_reload;
      end else if (expire && st_q == ST_SCAN && polls_left) begin
        t_load = 1'b1;
      end
    end
  end

  pst_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .cancel   (t_cancel),
    .load_val (t_val),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      mask_q  <= 1'b1;
      scan_q  <= 1'b0;
      en_q    <= 1'b0;
      polls_q <= '0;
    end else begin
      en_q   <= trig_en;
      scan_q <= 1'b0;
      if (en_fall) begin
        if (st_q == ST_IDLE || st_q == ST_POLL_ARMED) mask_q <= 1'b1;
        st_q <= ST_OFF;
      end else if (pen_go) begin
        st_q    <= ST_SCAN;
        polls_q <= '0;
        mask_q  <= 1'b1;
        scan_q  <= 1'b1;
      end else if (en_rise && st_q == ST_OFF) begin
        st_q   <= ST_IDLE;
        mask_q <= 1'b0;
      end else if (expire) begin
        case (st_q)
          ST_SCAN: begin
            if (polls_left) begin
              polls_q <= polls_nx;
              if (polls_nx >= CW'(MIN_POLLS)) begin
                st_q   <= ST_POLL_ARMED;
                mask_q <= 1'b0;
              end else begin
                st_q <= ST_POLL_MASKED;
              end
            end else begin
              st_q   <= ST_IDLE;
              mask_q <= 1'b0;
            end
          end
          ST_POLL_ARMED: begin
            mask_q <= 1'b1;
            st_q   <= ST_SCAN;
            scan_q <= 1'b1;
          end
          ST_POLL_MASKED: begin
            st_q   <= ST_SCAN;
            scan_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign scan_start = scan_q;
  assign irq_mask   = mask_q;
  assign state      = st_q;

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == ST_OFF && mask_q && !scan_q));
  // R5: scan pulse is one cycle wide and only seen in SCAN with mask high
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    scan_q |=> !scan_q);
  a_r5_pulse_in_scan: assert property (@(posedge clk) disable iff (rst)
    scan_q |-> (st_q == ST_SCAN && mask_q));
  // R3: disable always lands in OFF with the mask raised
  a_r3_disable: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> (st_q == ST_OFF && mask_q));
  // R7: masked poll keeps mask high, armed poll keeps it low
  a_r7_masked_poll: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POLL_MASKED) |-> mask_q);
  a_r7_armed_poll: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POLL_ARMED) |-> !mask_q);
  // R11: idle holds without pen or disable
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !pen_go && !en_fall) |=> (st_q == ST_IDLE));
  // R8: poll count never exceeds its limit
  a_r8_poll_limit: assert property (@(posedge clk) disable iff (rst)
    polls_q <= CW'(TOTAL_POLLS));
endmodule

// File: tb/pen_scan_trigger_tb.sv
`timescale 1ns/1ps
module pen_scan_trigger_tb;
  localparam int TW = 24;
  localparam int NV = 5;
  localparam int VI [NV] = '{20, 12, 16, 8, 10};
  localparam int VD [NV] = '{5, 11, 3, 8, 14};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig_en = 1'b0;
  logic          pen_irq = 1'b0;
  logic          scan_done = 1'b0;
  logic [TW-1:0] scan_interval = TW'(20);
  logic          scan_start;
  logic          irq_mask;
  logic [2:0]    state;
  logic          overrun;

  int checks = 0;
  int errors = 0;
  bit exp_ovr = 1'b0;

  always #2.5 clk = ~clk;

  pen_scan_trigger #(.TW(TW)) u_dut (
    .clk (clk), .rst (rst), .trig_en (trig_en), .pen_irq (pen_irq),
    .scan_done (scan_done), .scan_interval (scan_interval),
    .scan_start (scan_start), .irq_mask (irq_mask), .state (state),
    .overrun (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pen press from an unmasked state; scan must appear on the 3rd edge (R4, R5)
  task automatic press_pen();
    int n = 0;
    @(negedge clk);
    pen_irq = 1'b1;
    while (!scan_start && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R4 pen latency", n, 3);
    pen_irq = 1'b0;
    chk(state == 3'd4 && irq_mask, "R5 enter scan masked", int'(state), 4);
  endtask

  // called at the negedge where scan_start is seen high
  task automatic serve_scan(input int iv, input int dur);
    int n = 0;
    int exp;
    exp = (dur >= iv) ? dur + 2 : iv + 1;
    if (dur >= iv) exp_ovr = 1'b1;
    while (state == 3'd4 && n < 5000) begin
      @(negedge clk);
      n++;
      if (n == 1) chk(!scan_start, "R5 pulse one cycle", int'(scan_start), 0);
      scan_done = (n == dur);
    end
    scan_done = 1'b0;
    if (dur >= iv) chk(n == exp, "R10 saturated reload timing", n, exp);
    else           chk(n == exp, "R6 reload timing", n, exp);
  endtask

  task automatic wait_scan(input int iv);
    int n = 0;
    while (!scan_start && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == iv, "R9 poll to scan spacing", n, iv);
  endtask

  task automatic run_scans(input int iv, input int dur, input int first, input int last);
    for (int s = first; s <= last; s++) begin
      serve_scan(iv, dur);
      if (s < 6) begin
        if (s + 1 < 3) chk(state == 3'd2 && irq_mask, "R7 masked poll", int'(state), 2);
        else            chk(state == 3'd3 && !irq_mask, "R7 armed poll", int'(state), 3);
        if (s < last) wait_scan(iv);
      end else begin
        chk(state == 3'd1 && !irq_mask, "R8 idle after 7 scans", int'(state), 1);
      end
    end
  endtask

  task automatic quiet(input int cycles, input int st, input string req);
    int seen = 0;
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (scan_start) seen++;
      if (int'(state) != st) bad++;
    end
    chk(seen == 0 && bad == 0, req, seen + bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(state == 3'd0, "R1 reset state", int'(state), 0);
    chk(irq_mask && !scan_start && !overrun, "R1 reset outputs", int'(irq_mask), 1);
    // R4: pen ignored in OFF
    pen_irq = 1'b1;
    quiet(10, 0, "R4 pen ignored while off");
    pen_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R2
    trig_en = 1'b1;
    @(negedge clk);
    chk(state == 3'd1 && !irq_mask, "R2 enable to idle", int'(state), 1);
    quiet(40, 1, "R11 idle holds");

    // vector table: one full burst per entry
    for (int v = 0; v < NV; v++) begin
      scan_interval = TW'(VI[v]);
      press_pen();
      run_scans(VI[v], VD[v], 0, 6);
      chk(overrun == exp_ovr, "R10 overrun flag", int'(overrun), int'(exp_ovr));
    end
    quiet(50, 1, "R11 idle after burst");

    // R12: retrigger in armed poll restarts the count
    scan_interval = TW'(20);
    press_pen();
    run_scans(20, 5, 0, 2);
    chk(state == 3'd3, "R12 reached armed poll", int'(state), 3);
    press_pen();
    run_scans(20, 5, 0, 6);
    chk(state == 3'd1, "R12 second burst complete", int'(state), 1);

    // R3: disable during masked poll cancels the countdown
    press_pen();
    run_scans(20, 5, 0, 0);
    @(negedge clk);
    trig_en = 1'b0;
    @(negedge clk);
    chk(state == 3'd0 && irq_mask, "R3 disable from poll", int'(state), 0);
    pen_irq = 1'b1;
    quiet(60, 0, "R3 no scan after disable");
    pen_irq = 1'b0;
    repeat (3) @(negedge clk);
    trig_en = 1'b1;
    @(negedge clk);
    chk(state == 3'd1 && !irq_mask, "R2 re-enable", int'(state), 1);
    trig_en = 1'b0;
    @(negedge clk);
    chk(state == 3'd0 && irq_mask, "R3 disable from idle", int'(state), 0);
    quiet(20, 0, "R11 off holds");
    chk(overrun, "R10 overrun still set", int'(overrun), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule